// File: doc/BRIEF.md
# Prescaled Saturating Charge Accumulator

This block turns a stream of signed direction-change pulses from an external integrator into a 16-bit charge count. Each accepted pulse moves a bidirectional residue counter whose modulus is a power of two chosen by a 3-bit select. When the residue wraps upward the charge count rises by one, and when it wraps downward the count falls by one. The count clamps at its end values instead of wrapping around, and a flag reports that an end value was reached.

The host can overwrite the charge count and the two comparison thresholds at any time. A charge-complete level, when that mode is enabled, forces the count to full scale. A shutdown input freezes the count and discards the partial residue. Two registered flags report, every clock, whether the count lies strictly above the upper threshold or strictly below the lower one.

Top module: `chg_accum`

## Requirements
- R1: The residue modulus is M = 2^k with k = `scale_sel` (k = 0..7, so M = 1..128). With k = 0, every accepted pulse moves the count by one.
- R2: An accepted pulse with `step_dir` = 1 raises the residue. When the residue is already M-1, the pulse instead sets the residue to 0 and raises the charge count by one in the same clock edge.
- R3: An accepted pulse with `step_dir` = 0 lowers the residue. When the residue is already 0, the pulse instead reloads it to M-1 and lowers the charge count by one in the same clock edge. The residue is 0 after reset.
- R4: The charge count never wraps. An upward step at FFFFh leaves it at FFFFh, and a downward step at 0000h leaves it at 0000h.
- R5: `limit_flag` goes to 1 after a count step whose result is FFFFh or 0000h, including a blocked step. It goes to 0 after a count step with any other result, and after a host write or a charge-complete force. It is 0 after reset.
- R6: After reset, `acc_value` is 7FFFh, the upper threshold is FFFFh, the lower threshold is 0000h, and all flags are 0.
- R7: While `cc_enable` and `cc_level` are both 1, the count becomes FFFFh on the next edge. This overrides a host write and a count step. `cc_level` has no effect while `cc_enable` is 0.
- R8: `acc_wr_en` loads `acc_wr_data` on the next edge and overrides a count step in the same cycle.
- R9: While `halt` is 1, pulses are ignored and the count is kept. The residue is cleared to 0.
- R10: `above_hi` is 1 exactly when, at the previous edge, the count was strictly greater (unsigned) than the upper threshold.
- R11: `below_lo` is 1 exactly when, at the previous edge, the count was strictly less (unsigned) than the lower threshold.
- R12: `hi_wr_en` and `lo_wr_en` load the upper and lower thresholds from their data inputs on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_valid | input | 1 | One direction-change pulse per cycle at 1 |
| step_dir | input | 1 | Pulse polarity: 1 = charge in, 0 = charge out |
| scale_sel | input | 3 | Prescale exponent k |
| halt | input | 1 | Shutdown: ignore pulses, clear residue |
| cc_enable | input | 1 | Charge-complete mode enable |
| cc_level | input | 1 | Charge-complete level |
| acc_wr_en | input | 1 | Host write strobe for the count |
| acc_wr_data | input | 16 | Host value for the count |
| hi_wr_en | input | 1 | Host write strobe for the upper threshold |
| hi_wr_data | input | 16 | Upper threshold value |
| lo_wr_en | input | 1 | Host write strobe for the lower threshold |
| lo_wr_data | input | 16 | Lower threshold value |
| acc_value | output | 16 | Charge count |
| limit_flag | output | 1 | Count at an end value after the last step |
| above_hi | output | 1 | Count strictly above the upper threshold |
| below_lo | output | 1 | Count strictly below the lower threshold |

## Verification
The hardest situation to reach from the ports is a residue left mid-way, because the residue is never visible. The stimulus gets there by issuing pulse counts that are not multiples of M. It then infers the residue from exactly which later pulse moves the count. This covers the wrap at M-1, the reload on a downward wrap, and the clear under shutdown. With M = 128 a full downward cycle of pulses is driven so that the reload shows as a gap of exactly 128 pulses. Saturation is reached by writing values one step from each end and stepping across.

// File: rtl/chg_pkg.sv
package chg_pkg;
    localparam int ACC_W = 16;
    localparam int SEL_W = 3;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             limit;
    } acc_state_t;

    typedef struct packed {
        logic [ACC_W-1:0] hi;
        logic [ACC_W-1:0] lo;
        logic             above;
        logic             below;
    } win_state_t;
endpackage

// File: rtl/chg_prescale.sv
module chg_prescale #(
    parameter int SEL_W = chg_pkg::SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse,
    input  logic             up,
    input  logic             halt,
    input  logic [SEL_W-1:0] sel,
    output logic             carry,
    output logic             borrow
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W:0]   full;
    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] eff;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        full   = (CNT_W+1)'(1) << sel;
        mask   = CNT_W'(full - (CNT_W+1)'(1));
        eff    = cnt_q & mask;
        cnt_d  = eff;
        carry  = 1'b0;
        borrow = 1'b0;
        if (halt) begin
            cnt_d = '0;
        end else if (pulse) begin
            if (up) begin
                if (eff == mask) begin
                    cnt_d = '0;
                    carry = 1'b1;
                end else begin
                    cnt_d = eff + CNT_W'(1);
                end
            end else begin
                if (eff == '0) begin
                    cnt_d  = mask;
                    borrow = 1'b1;
                end else begin
                    cnt_d = eff - CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/chg_sat_acc.sv
module chg_sat_acc
    import chg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_up,
    input  logic             step_dn,
    input  logic             wr_en,
    input  logic [ACC_W-1:0] wr_data,
    input  logic             force_full,
    output logic [ACC_W-1:0] acc,
    output logic             limit
);
    localparam logic [ACC_W-1:0] TOP = '1;
    localparam logic [ACC_W-1:0] BOT = '0;
    localparam logic [ACC_W-1:0] MID = {1'b0, {(ACC_W-1){1'b1}}};

    acc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (force_full) begin
            st_d.acc   = TOP;
            st_d.limit = 1'b0;
        end else if (wr_en) begin
            st_d.acc   = wr_data;
            st_d.limit = 1'b0;
        end else if (step_up) begin
            st_d.acc   = (st_q.acc == TOP) ? TOP : st_q.acc + ACC_W'(1);
            st_d.limit = (st_d.acc == TOP);
        end else if (step_dn) begin
            st_d.acc   = (st_q.acc == BOT) ? BOT : st_q.acc - ACC_W'(1);
            st_d.limit = (st_d.acc == BOT);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.acc   <= MID;
            st_q.limit <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc   = st_q.acc;
    assign limit = st_q.limit;
endmodule

// File: rtl/chg_window.sv
module chg_window
    import chg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] acc,
    input  logic             hi_wr_en,
    input  logic [ACC_W-1:0] hi_wr_data,
    input  logic             lo_wr_en,
    input  logic [ACC_W-1:0] lo_wr_data,
    output logic [ACC_W-1:0] hi_thr,
    output logic [ACC_W-1:0] lo_thr,
    output logic             above,
    output logic             below
);
    win_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.above = (acc > st_q.hi);
        st_d.below = (acc < st_q.lo);
        if (hi_wr_en) st_d.hi = hi_wr_data;
        if (lo_wr_en) st_d.lo = lo_wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hi    <= '1;
            st_q.lo    <= '0;
            st_q.above <= 1'b0;
            st_q.below <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hi_thr = st_q.hi;
    assign lo_thr = st_q.lo;
    assign above  = st_q.above;
    assign below  = st_q.below;
endmodule

// File: rtl/chg_accum.sv
module chg_accum
    import chg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_valid,
    input  logic             step_dir,
    input  logic [SEL_W-1:0] scale_sel,
    input  logic             halt,
    input  logic             cc_enable,
    input  logic             cc_level,
    input  logic             acc_wr_en,
    input  logic [ACC_W-1:0] acc_wr_data,
    input  logic             hi_wr_en,
    input  logic [ACC_W-1:0] hi_wr_data,
    input  logic             lo_wr_en,
    input  logic [ACC_W-1:0] lo_wr_data,
    output logic [ACC_W-1:0] acc_value,
    output logic             limit_flag,
    output logic             above_hi,
    output logic             below_lo
);
    logic             step_up;
    logic             step_dn;
    logic             cc_force;
    logic [ACC_W-1:0] hi_thr;
    logic [ACC_W-1:0] lo_thr;

    assign cc_force = cc_enable & cc_level;

    chg_prescale #(.SEL_W(SEL_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .pulse  (step_valid),
        .up     (step_dir),
        .halt   (halt),
        .sel    (scale_sel),
        .carry  (step_up),
        .borrow (step_dn)
    );

    chg_sat_acc u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_up    (step_up),
        .step_dn    (step_dn),
        .wr_en      (acc_wr_en),
        .wr_data    (acc_wr_data),
        .force_full (cc_force),
        .acc        (acc_value),
        .limit      (limit_flag)
    );

    chg_window u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (acc_value),
        .hi_wr_en   (hi_wr_en),
        .hi_wr_data (hi_wr_data),
        .lo_wr_en   (lo_wr_en),
        .lo_wr_data (lo_wr_data),
        .hi_thr     (hi_thr),
        .lo_thr     (lo_thr),
        .above      (above_hi),
        .below      (below_lo)
    );
endmodule

// File: rtl/chg_accum_chk.sv
module chg_accum_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        step_valid,
    input logic        halt,
    input logic [2:0]  scale_sel,
    input logic        cc_enable,
    input logic        cc_level,
    input logic        acc_wr_en,
    input logic [15:0] acc_value,
    input logic        step_up,
    input logic        step_dn,
    input logic [15:0] hi_thr,
    input logic [15:0] lo_thr,
    input logic        above_hi,
    input logic        below_lo,
    input logic        limit_flag
);
    logic quiet;
    assign quiet = !acc_wr_en && !(cc_enable && cc_level);

    a_r1_unit_scale: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && !halt && scale_sel == 3'd0) |-> (step_up || step_dn));

    a_r4_hold_top: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && step_up && acc_value == 16'hFFFF) |=> acc_value == 16'hFFFF);

    a_r4_hold_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && step_dn && acc_value == 16'h0000) |=> acc_value == 16'h0000);

    a_r5_limit_reach: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && step_up && acc_value == 16'hFFFE) |=> limit_flag);

    a_r7_cc_full: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_enable && cc_level) |=> acc_value == 16'hFFFF);

    a_r9_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && quiet) |=> $stable(acc_value));

    a_r10_above: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_value > hi_thr) |=> above_hi);

    a_r11_below: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_value < lo_thr) |=> below_lo);
endmodule

bind chg_accum chg_accum_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_valid (step_valid),
    .halt       (halt),
    .scale_sel  (scale_sel),
    .cc_enable  (cc_enable),
    .cc_level   (cc_level),
    .acc_wr_en  (acc_wr_en),
    .acc_value  (acc_value),
    .step_up    (step_up),
    .step_dn    (step_dn),
    .hi_thr     (hi_thr),
    .lo_thr     (lo_thr),
    .above_hi   (above_hi),
    .below_lo   (below_lo),
    .limit_flag (limit_flag)
);

// File: tb/sim_chg_accum.sv
module sim_chg_accum;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam int NVEC       = 18;

    localparam logic [3:0] OP_WR  = 4'd0;
    localparam logic [3:0] OP_SEL = 4'd1;
    localparam logic [3:0] OP_UP  = 4'd2;
    localparam logic [3:0] OP_DN  = 4'd3;
    localparam logic [3:0] OP_CC  = 4'd4;

    // {op, argument, expected count after the op}
    localparam logic [35:0] VEC [NVEC] = '{
        {OP_SEL, 16'd0,    16'h7FFF},  // R1 M=1
        {OP_UP,  16'd3,    16'h8002},  // R1 R2
        {OP_DN,  16'd5,    16'h7FFD},  // R1 R3
        {OP_SEL, 16'd2,    16'h7FFD},  // M=4
        {OP_UP,  16'd7,    16'h7FFE},  // R2 residue left at 3
        {OP_UP,  16'd1,    16'h7FFF},  // R2 wrap at M-1
        {OP_DN,  16'd1,    16'h7FFE},  // R3 borrow from 0
        {OP_DN,  16'd4,    16'h7FFD},  // R3 reload to M-1
        {OP_WR,  16'hFFFE, 16'hFFFE},  // R8
        {OP_SEL, 16'd0,    16'hFFFE},
        {OP_UP,  16'd3,    16'hFFFF},  // R4 top clamp
        {OP_DN,  16'd1,    16'hFFFE},
        {OP_WR,  16'h0001, 16'h0001},  // R8
        {OP_DN,  16'd3,    16'h0000},  // R4 bottom clamp
        {OP_CC,  16'd0,    16'hFFFF},  // R7
        {OP_SEL, 16'd7,    16'hFFFF},  // M=128
        {OP_DN,  16'd128,  16'hFFFE},  // R1 R3 first borrow then 127 more
        {OP_DN,  16'd1,    16'hFFFD}   // R3 second borrow after 128 pulses
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_valid = 1'b0;
    logic        step_dir = 1'b0;
    logic [2:0]  scale_sel = 3'd7;
    logic        halt = 1'b0;
    logic        cc_enable = 1'b0;
    logic        cc_level = 1'b0;
    logic        acc_wr_en = 1'b0;
    logic [15:0] acc_wr_data = '0;
    logic        hi_wr_en = 1'b0;
    logic [15:0] hi_wr_data = '0;
    logic        lo_wr_en = 1'b0;
    logic [15:0] lo_wr_data = '0;
    logic [15:0] acc_value;
    logic        limit_flag;
    logic        above_hi;
    logic        below_lo;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chg_accum u0 (.*);

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic pulses(input logic dir, input int n);
        for (int i = 0; i < n; i++) begin
            step_valid = 1'b1;
            step_dir   = dir;
            cyc();
        end
        step_valid = 1'b0;
    endtask

    task automatic wr_acc(input logic [15:0] v);
        acc_wr_en = 1'b1; acc_wr_data = v; cyc(); acc_wr_en = 1'b0;
    endtask

    initial begin
        while (cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
        // R6 reset state
        chk("R6 count", acc_value, 16'h7FFF);
        chk("R6 flags", {13'd0, limit_flag, above_hi, below_lo}, 16'h0000);

        for (int v = 0; v < NVEC; v++) begin
            case (VEC[v][35:32])
                OP_WR:  wr_acc(VEC[v][31:16]);
                OP_SEL: begin scale_sel = VEC[v][18:16]; cyc(); end
                OP_UP:  pulses(1'b1, int'(VEC[v][31:16]));
                OP_DN:  pulses(1'b0, int'(VEC[v][31:16]));
                default: begin
                    cc_enable = 1'b1; cc_level = 1'b1; cyc();
                    cc_level = 1'b0; cc_enable = 1'b0;
                end
            endcase
            chk($sformatf("R1-table vector %0d", v), acc_value, VEC[v][15:0]);
        end

        // R5 limit flag
        scale_sel = 3'd0;
        wr_acc(16'hFFFE);
        chk("R5 cleared by write", {15'd0, limit_flag}, 16'd0);
        pulses(1'b1, 1);
        chk("R5 set at top", {15'd0, limit_flag}, 16'd1);
        pulses(1'b1, 1);
        chk("R5 kept while clamped", {15'd0, limit_flag}, 16'd1);
        pulses(1'b0, 1);
        chk("R5 cleared off limit", {15'd0, limit_flag}, 16'd0);

        // R8 write beats a step
        acc_wr_en = 1'b1; acc_wr_data = 16'h1234; step_valid = 1'b1; step_dir = 1'b1;
        cyc();
        acc_wr_en = 1'b0; step_valid = 1'b0;
        chk("R8 write over step", acc_value, 16'h1234);

        // R7 force beats a write; level ignored when mode off
        cc_enable = 1'b1; cc_level = 1'b1; acc_wr_en = 1'b1; acc_wr_data = 16'h0042;
        cyc();
        acc_wr_en = 1'b0; cc_level = 1'b0; cc_enable = 1'b0;
        chk("R7 force over write", acc_value, 16'hFFFF);
        wr_acc(16'h2000);
        cc_level = 1'b1; cyc(); cyc(); cc_level = 1'b0;
        chk("R7 level ignored when disabled", acc_value, 16'h2000);

        // R9 shutdown
        scale_sel = 3'd2;
        cyc();
        pulses(1'b1, 2);
        halt = 1'b1;
        pulses(1'b1, 5);
        chk("R9 pulses ignored", acc_value, 16'h2000);
        halt = 1'b0;
        pulses(1'b1, 2);
        chk("R9 residue cleared", acc_value, 16'h2000);
        pulses(1'b1, 2);
        chk("R9 counting resumes", acc_value, 16'h2001);

        // R12 thresholds, R10 and R11 strict compare
        hi_wr_en = 1'b1; hi_wr_data = 16'h1000;
        lo_wr_en = 1'b1; lo_wr_data = 16'h0800;
        cyc();
        hi_wr_en = 1'b0; lo_wr_en = 1'b0;
        wr_acc(16'h1001); cyc();
        chk("R10 R12 above", {15'd0, above_hi}, 16'd1);
        wr_acc(16'h1000); cyc();
        chk("R10 equal is not above", {15'd0, above_hi}, 16'd0);
        wr_acc(16'h07FF); cyc();
        chk("R11 R12 below", {15'd0, below_lo}, 16'd1);
        wr_acc(16'h0800); cyc();
        chk("R11 equal is not below", {15'd0, below_lo}, 16'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule